// File: doc/BRIEF.md
# Split Instruction/Data Software-Refilled TLB Lookup

This block translates a 32-bit effective address through a small set-associative translation buffer that software fills. The buffer is split into an instruction bank and a data bank. Each bank has several ways, and each way has a number of sets. A request carries the address, the access kind (fetch, load or store), a precomputed page-table compare word, the protection key and a no-execute flag. The request is registered. The next clock edge delivers the real-address word, the RWX rights and a granted/denied/miss status.

The ways of the selected set are compared in parallel. The first matching way is the reference for consistency, and any later matching way whose translation bits differ from it is ignored. When a match exists, the block writes the entry back with the referenced bit set. If the changed bit is still clear, a granted store sets it. Every other access has its write right withheld, so the first store to a clean page faults. A miss stores the compare word in an instruction-side or data-side compare register. Software loads entries through a direct write port.

Top module: `swtlb_lookup`

## Requirements
- R1: The set is address bits [PAGE_BITS+SET_W-1:PAGE_BITS]. Fetches (access code 0) use the instruction bank and loads (1) and stores (2) use the data bank. An entry's index is {bank, way, set}, with bank 1 for instruction, and upd_idx reports this index.
- R2: A way matches only if all of the following hold: its stored page word equals the address with the low PAGE_BITS cleared; first-word bit 31 (valid) is 1; first-word bit 6 (secondary-hash) is 0; and the first word ANDed with 0x7FFFFFBF equals the compare word.
- R3: The first matching way is the consistency reference. A later matching way whose second word differs from it in bits [31:12], [6:3] or [1:0] is skipped.
- R4: Rights come from second-word bits [1:0] (pp) and the key, with perm = {x,w,r}. With key 0, read is always allowed and write is allowed unless pp=3. With key 1, read is allowed unless pp=0 and write only when pp=2. Execute equals read unless no-execute is set.
- R5: A fetch needs x, a load needs r and a store needs w. Status 0 (granted) picks the lowest consistent way that allows the access. Status 2 (denied) picks the highest consistent matching way. Status 1 is a miss.
- R6: On a match, upd_word is the winning entry's second word with bit 8 (referenced) set, and that value is written back into the entry. rsp_raddr is the entry's second word before the update.
- R7: When the winner's bit 7 (changed) is 0, a granted store sets it in upd_word. Any other access clears w in rsp_perm.
- R8: A miss copies the compare word into icmp for a fetch or into dcmp otherwise. The other register keeps its value.
- R9: A miss returns rsp_raddr all ones and rsp_perm 0, and raises no update.
- R10: A request sampled at edge N is answered after edge N+1. A request issued on the next cycle sees the write-back of the previous request.
- R11: After reset, rsp_valid, upd_en, icmp and dcmp are 0 and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Effective address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_cmp | input | 32 | Compare word for the first entry word |
| req_key | input | 1 | Protection key |
| req_nx | input | 1 | No-execute flag |
| sw_we | input | 1 | Software entry write strobe |
| sw_side | input | 1 | Bank to write: 1 instruction, 0 data |
| sw_way | input | $clog2(WAYS) | Way to write |
| sw_set | input | $clog2(SETS) | Set to write |
| sw_epn | input | 32 | Page-aligned effective address of the entry |
| sw_hi | input | 32 | First entry word (valid, VSID, hash select, API) |
| sw_lo | input | 32 | Second entry word (RPN, R, C, WIMG, PP) |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 granted, 1 miss, 2 denied |
| rsp_raddr | output | 32 | Second word of the winning entry |
| rsp_perm | output | 3 | Returned rights {x,w,r} |
| upd_en | output | 1 | Write-back strobe |
| upd_idx | output | $clog2(2*WAYS*SETS) | Index of the updated entry |
| upd_word | output | 32 | Updated second word |
| icmp | output | 32 | Instruction-side miss compare register |
| dcmp | output | 32 | Data-side miss compare register |

## Verification
The rights path is swept over every combination of pp, key, no-execute flag, access kind and changed bit. This separates the permission table from the first-write rule. A sweep over all sets, with entries alternating between ways, checks the set and way indexing. The same addresses are then fetched against an empty instruction bank to check bank separation and the routing of the compare registers. Single-field corruptions of an entry (valid, hash select, compare word, page) each must miss. Two-way patterns of consistent-granted, consistent-denied, inconsistent-pp and differing-RPN entries check the winner choice, and back-to-back lookups show the write-back feeding the next request.

// File: rtl/swtlb_pkg.sv
// Shared types and helpers for the software-refilled TLB lookup.
// Assumes 32-bit entry words in the classic hashed page-table layout.
package swtlb_pkg;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] CMP_MASK = 32'h7FFF_FFBF;
    localparam int BIT_VALID = 31;
    localparam int BIT_HSEL  = 6;
    localparam int BIT_REF   = 8;
    localparam int BIT_CHG   = 7;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_GRANT = 2'd0,
        ST_MISS  = 2'd1,
        ST_DENY  = 2'd2
    } stat_e;

    typedef struct packed {
        logic [WORD_W-1:0] epn;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } entry_t;

    // Map pp bits and key to rights {x,w,r}
    function automatic logic [2:0] pp_to_perm(logic [1:0] pp, logic key, logic nx);
        logic r, w;
        if (!key) begin
            r = 1'b1;
            w = (pp != 2'd3);
        end else begin
            r = (pp != 2'd0);
            w = (pp == 2'd2);
        end
        return {r & ~nx, w, r};
    endfunction

    // True when the rights cover the access kind
    function automatic logic perm_ok(logic [2:0] perm, logic [1:0] acc);
        case (acc)
            ACC_FETCH: return perm[2];
            ACC_LOAD:  return perm[0];
            ACC_STORE: return perm[1];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/swtlb_store.sv
// Entry array for both banks. Index is {bank, way, set}.
// Assumes WAYS and SETS are powers of two. A software write wins over
// a same-cycle write-back to the same entry. Reads are combinational.
module swtlb_store
    import swtlb_pkg::*;
#(
    parameter int WAYS = 2,
    parameter int SETS = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sw_we,
    input  logic [$clog2(2*WAYS*SETS)-1:0]    sw_idx,
    input  entry_t                            sw_ent,
    input  logic                              up_we,
    input  logic [$clog2(2*WAYS*SETS)-1:0]    up_idx,
    input  logic [WORD_W-1:0]                 up_lo,
    input  logic                              rd_side,
    input  logic [$clog2(SETS)-1:0]           rd_set,
    output entry_t                            rd_ent [WAYS]
);
    localparam int DEPTH = 2 * WAYS * SETS;
    localparam int WAY_W = $clog2(WAYS);

    entry_t mem [DEPTH];

    // Array update: reset clears, write-back then software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (up_we) mem[up_idx].lo <= up_lo;
            if (sw_we) mem[sw_idx] <= sw_ent;
        end
    end

    // One read port per way of the selected set
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_ent[w] = mem[{rd_side, WAY_W'(w), rd_set}];
    end

endmodule

// File: rtl/swtlb_match.sv
// Tag compare for one way: page, valid, hash select and compare word.
// Assumes the stored page word is page-aligned for a match to occur.
module swtlb_match
    import swtlb_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  entry_t            ent,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] cmp,
    output logic              hit
);
    localparam logic [WORD_W-1:0] PAGE_MASK = ~((WORD_W'(1) << PAGE_BITS) - WORD_W'(1));

    // Hit when every field of the entry agrees with the request
    always_comb begin
        hit = ((addr & PAGE_MASK) == ent.epn) &&
              ent.hi[BIT_VALID] && !ent.hi[BIT_HSEL] &&
              ((ent.hi & CMP_MASK) == cmp);
    end

endmodule

// File: rtl/swtlb_pick.sv
// Walks the per-way hits in way order. The first hit is the consistency
// reference, a granting way ends the walk, and a denying way is
// replaced by later consistent ones.
module swtlb_pick
    import swtlb_pkg::*;
#(
    parameter int WAYS = 2,
    parameter logic [WORD_W-1:0] CHECK_MASK = 32'hFFFF_F07B
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WAYS-1:0]           hit,
    input  logic [WORD_W-1:0]         lo [WAYS],
    input  logic [1:0]                acc,
    input  logic                      key,
    input  logic                      nx,
    output logic                      found,
    output logic [$clog2(WAYS)-1:0]   win,
    output logic [2:0]                perm,
    output logic                      grant
);
    localparam int WAY_W = $clog2(WAYS);

    // Ordered selection among consistent matching ways
    always_comb begin
        logic have;
        logic done;
        logic [WORD_W-1:0] ref_w;
        logic [2:0] p;
        have = 1'b0; done = 1'b0; ref_w = '0; p = '0;
        win = '0; perm = '0; grant = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit[w] && !done && (!have || ((lo[w] ^ ref_w) & CHECK_MASK) == '0)) begin
                if (!have) ref_w = lo[w];
                have = 1'b1;
                win  = WAY_W'(w);
                p    = pp_to_perm(lo[w][1:0], key, nx);
                perm = p;
                if (perm_ok(p, acc)) begin
                    grant = 1'b1;
                    done  = 1'b1;
                end
            end
        end
        found = have;
    end

    // A grant needs a hit in the winning way
    assert_grant_has_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (found && hit[win]));

endmodule

// File: rtl/swtlb_lookup.sv
// Top of the split instruction/data TLB lookup. A request is registered,
// looked up against every way in parallel, and answered one edge later
// together with the referenced/changed write-back. A miss records the
// compare word on the bank's side.
// Assumes WAYS >= 2 and SETS are powers of two.
module swtlb_lookup
    import swtlb_pkg::*;
#(
    parameter int WAYS      = 2,
    parameter int SETS      = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [31:0]                       req_addr,
    input  logic [1:0]                        req_acc,
    input  logic [31:0]                       req_cmp,
    input  logic                              req_key,
    input  logic                              req_nx,
    input  logic                              sw_we,
    input  logic                              sw_side,
    input  logic [$clog2(WAYS)-1:0]           sw_way,
    input  logic [$clog2(SETS)-1:0]           sw_set,
    input  logic [31:0]                       sw_epn,
    input  logic [31:0]                       sw_hi,
    input  logic [31:0]                       sw_lo,
    output logic                              rsp_valid,
    output logic [1:0]                        rsp_status,
    output logic [31:0]                       rsp_raddr,
    output logic [2:0]                        rsp_perm,
    output logic                              upd_en,
    output logic [$clog2(2*WAYS*SETS)-1:0]    upd_idx,
    output logic [31:0]                       upd_word,
    output logic [31:0]                       icmp,
    output logic [31:0]                       dcmp
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);
    localparam int IDX_W = $clog2(2*WAYS*SETS);
    localparam logic [WORD_W-1:0] PAGE_MASK  = ~((WORD_W'(1) << PAGE_BITS) - WORD_W'(1));
    localparam logic [WORD_W-1:0] CHECK_MASK = PAGE_MASK | 32'h0000_007B;

    logic              q_vld;
    logic [31:0]       q_addr;
    logic [1:0]        q_acc;
    logic [31:0]       q_cmp;
    logic              q_key;
    logic              q_nx;

    logic              side;
    logic [SET_W-1:0]  set_idx;
    entry_t            way_ent [WAYS];
    logic [31:0]       way_lo  [WAYS];
    logic [WAYS-1:0]   way_hit;
    logic              pk_found;
    logic [WAY_W-1:0]  pk_win;
    logic [2:0]        pk_perm;
    logic              pk_grant;

    logic [1:0]        res_status;
    logic [31:0]       res_raddr;
    logic [2:0]        res_perm;
    logic [31:0]       res_word;
    logic [IDX_W-1:0]  res_idx;
    logic              res_upd;

    // Request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= 1'b0; q_addr <= '0; q_acc <= '0;
            q_cmp <= '0;   q_key  <= 1'b0; q_nx <= 1'b0;
        end else begin
            q_vld <= req_valid;
            if (req_valid) begin
                q_addr <= req_addr; q_acc <= req_acc; q_cmp <= req_cmp;
                q_key  <= req_key;  q_nx  <= req_nx;
            end
        end
    end

    assign side    = (q_acc == ACC_FETCH);
    assign set_idx = q_addr[PAGE_BITS +: SET_W];

    swtlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_idx({sw_side, sw_way, sw_set}),
        .sw_ent('{epn: sw_epn, hi: sw_hi, lo: sw_lo}),
        .up_we(res_upd), .up_idx(res_idx), .up_lo(res_word),
        .rd_side(side), .rd_set(set_idx), .rd_ent(way_ent)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_lo[w] = way_ent[w].lo;
        swtlb_match #(.PAGE_BITS(PAGE_BITS)) u_match (
            .ent(way_ent[w]), .addr(q_addr), .cmp(q_cmp), .hit(way_hit[w])
        );
    end

    swtlb_pick #(.WAYS(WAYS), .CHECK_MASK(CHECK_MASK)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .hit(way_hit), .lo(way_lo), .acc(q_acc), .key(q_key), .nx(q_nx),
        .found(pk_found), .win(pk_win), .perm(pk_perm), .grant(pk_grant)
    );

    // Result and write-back word, including the first-write rule
    always_comb begin
        res_status = ST_MISS;
        res_raddr  = '1;
        res_perm   = '0;
        res_word   = '0;
        res_idx    = '0;
        res_upd    = 1'b0;
        if (pk_found) begin
            res_idx    = {side, pk_win, set_idx};
            res_raddr  = way_lo[pk_win];
            res_perm   = pk_perm;
            res_status = pk_grant ? ST_GRANT : ST_DENY;
            res_word   = way_lo[pk_win];
            res_word[BIT_REF] = 1'b1;
            if (!way_lo[pk_win][BIT_CHG]) begin
                if (q_acc == ACC_STORE && pk_grant) res_word[BIT_CHG] = 1'b1;
                else                                res_perm[1]       = 1'b0;
            end
            res_upd = q_vld;
        end
    end

    // Response, update report and miss compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_status <= '0; rsp_raddr <= '0; rsp_perm <= '0;
            upd_en <= 1'b0; upd_idx <= '0; upd_word <= '0;
            icmp <= '0; dcmp <= '0;
        end else begin
            rsp_valid <= q_vld;
            upd_en    <= res_upd;
            if (q_vld) begin
                rsp_status <= res_status;
                rsp_raddr  <= res_raddr;
                rsp_perm   <= res_perm;
                upd_idx    <= res_idx;
                upd_word   <= res_word;
                if (!pk_found) begin
                    if (side) icmp <= q_cmp;
                    else      dcmp <= q_cmp;
                end
            end
        end
    end

    // A miss in the instruction bank records the compare word in icmp
    assert_icmp_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_vld && !pk_found && side) |=> (icmp == $past(q_cmp) && $stable(dcmp)));

    // A miss raises no update and returns no rights
    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_MISS) |-> (!upd_en && rsp_perm == 3'b000));

    // Every hit writes back its entry with the referenced bit set
    assert_ref_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != ST_MISS) |-> (upd_en && upd_word[BIT_REF] &&
            ((upd_word ^ rsp_raddr) & ~32'h0000_0180) == '0));

    // A clean page never hands out write rights
    assert_first_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && upd_en && !upd_word[BIT_CHG]) |-> !rsp_perm[1]);

    // A response follows a registered request by one edge
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(q_vld));

endmodule

// File: tb/swtlb_lookup_tb.sv
`timescale 1ns/1ps
module swtlb_lookup_tb_top;
    localparam int WAYS = 2;
    localparam int SETS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] req_cmp = '0;
    logic        req_key = 1'b0;
    logic        req_nx = 1'b0;
    logic        sw_we = 1'b0;
    logic        sw_side = 1'b0;
    logic [0:0]  sw_way = '0;
    logic [4:0]  sw_set = '0;
    logic [31:0] sw_epn = '0, sw_hi = '0, sw_lo = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_raddr;
    logic [2:0]  rsp_perm;
    logic        upd_en;
    logic [6:0]  upd_idx;
    logic [31:0] upd_word;
    logic [31:0] icmp, dcmp;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    swtlb_lookup #(.WAYS(WAYS), .SETS(SETS), .PAGE_BITS(12)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_acc(req_acc),
        .req_cmp(req_cmp), .req_key(req_key), .req_nx(req_nx),
        .sw_we(sw_we), .sw_side(sw_side), .sw_way(sw_way), .sw_set(sw_set),
        .sw_epn(sw_epn), .sw_hi(sw_hi), .sw_lo(sw_lo),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_raddr(rsp_raddr),
        .rsp_perm(rsp_perm), .upd_en(upd_en), .upd_idx(upd_idx),
        .upd_word(upd_word), .icmp(icmp), .dcmp(dcmp)
    );

    always #10 clk = ~clk;

    localparam logic [31:0] CMP = 32'h2ABC_DE05;
    localparam logic [31:0] HI  = CMP | 32'h8000_0000;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_lo(input logic [19:0] rpn, input bit chg, input logic [1:0] pp);
        return {rpn, 3'b000, 1'b0, chg, 4'b0010, 1'b0, pp};
    endfunction

    // Rights table from R4
    function automatic logic [2:0] exp_perm(input logic [1:0] pp, input bit key, input bit nx);
        bit r, w;
        if (!key) begin r = 1; w = (pp != 3); end
        else begin r = (pp != 0); w = (pp == 2); end
        return {r & ~nx, w, r};
    endfunction

    function automatic bit acc_ok(input logic [2:0] p, input int acc);
        return (acc == 0) ? p[2] : (acc == 1) ? p[0] : p[1];
    endfunction

    task automatic load(input bit side, input int way, input int set, input logic [31:0] epn,
                        input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        sw_we = 1; sw_side = side; sw_way = 1'(way); sw_set = 5'(set);
        sw_epn = epn; sw_hi = hi; sw_lo = lo;
        @(negedge clk);
        sw_we = 0;
    endtask

    task automatic drive(input logic [31:0] a, input int acc, input logic [31:0] c, input bit k, input bit x);
        req_valid = 1; req_addr = a; req_acc = 2'(acc); req_cmp = c; req_key = k; req_nx = x;
    endtask

    // One lookup; returns after the response is visible
    task automatic look(input logic [31:0] a, input int acc, input logic [31:0] c, input bit k, input bit x);
        @(negedge clk);
        drive(a, acc, c, k, x);
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 0, "R10 early", 32'(rsp_valid), 0);
        @(negedge clk);
        chk(rsp_valid == 1, "R10 resp", 32'(rsp_valid), 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=1 exp=0");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(rsp_valid == 0, "R11 rsp_valid", 32'(rsp_valid), 0);
        chk(upd_en == 0, "R11 upd_en", 32'(upd_en), 0);
        chk(icmp == 0, "R11 icmp", icmp, 0);
        chk(dcmp == 0, "R11 dcmp", dcmp, 0);
        look(32'h1000_0000, 1, CMP, 0, 0);
        chk(rsp_status == 1, "R11 empty miss", 32'(rsp_status), 1);
        chk(rsp_raddr == 32'hFFFF_FFFF, "R9 raddr", rsp_raddr, 32'hFFFF_FFFF);
        chk(rsp_perm == 0 && upd_en == 0, "R9 perm/upd", {rsp_perm, upd_en}, 0);
        chk(dcmp == CMP && icmp == 0, "R8 dcmp", dcmp, CMP);

        // R4 R5 R7 sweep of rights
        for (int pp = 0; pp < 4; pp++)
        for (int k = 0; k < 2; k++)
        for (int x = 0; x < 2; x++)
        for (int acc = 0; acc < 3; acc++)
        for (int c = 0; c < 2; c++) begin
            logic [31:0] lo, ew;
            logic [2:0] ep;
            bit ok;
            lo = mk_lo(20'hABCDE, c[0], 2'(pp));
            load(acc == 0, 0, 3, 32'h5500_3000, HI, lo);
            look(32'h5500_3ABC, acc, CMP, k[0], x[0]);
            ep = exp_perm(2'(pp), k[0], x[0]);
            ok = acc_ok(ep, acc);
            ew = lo | 32'h100;
            if (!c[0]) begin
                if (acc == 2 && ok) ew = ew | 32'h80;
                else ep[1] = 1'b0;
            end
            chk(rsp_status == (ok ? 2'd0 : 2'd2), "R5 status", 32'(rsp_status), ok ? 0 : 2);
            chk(rsp_perm == ep, "R4 R7 perm", 32'(rsp_perm), 32'(ep));
            chk(rsp_raddr == lo, "R6 raddr", rsp_raddr, lo);
            chk(upd_en && upd_word == ew, "R7 upd_word", upd_word, ew);
            chk(upd_idx == 7'({acc == 0, 1'b0, 5'd3}), "R1 idx", 32'(upd_idx), 32'({acc == 0, 1'b0, 5'd3}));
        end

        // R1 set sweep over the data bank, then the same pages as fetches
        for (int s = 0; s < SETS; s++)
            load(0, s % 2, s, 32'h6600_0000 | (s << 12), HI, mk_lo(20'(s + 'h100), 1, 2));
        for (int s = 0; s < SETS; s++) begin
            look(32'h6600_0000 | (s << 12), 1, CMP, 0, 0);
            chk(rsp_status == 0 && rsp_raddr == mk_lo(20'(s + 'h100), 1, 2), "R1 set raddr",
                rsp_raddr, mk_lo(20'(s + 'h100), 1, 2));
            chk(upd_idx == 7'({1'b0, 1'(s % 2), 5'(s)}), "R1 set idx", 32'(upd_idx), 32'({1'b0, 1'(s % 2), 5'(s)}));
            look(32'h6600_0000 | (s << 12), 0, CMP ^ 32'(s << 8), 0, 0);
            chk(rsp_status == 1, "R1 fetch bank miss", 32'(rsp_status), 1);
            chk(icmp == (CMP ^ 32'(s << 8)) && dcmp == CMP, "R8 icmp", icmp, CMP ^ 32'(s << 8));
        end
        load(1, 1, 5, 32'h6600_5000, HI, mk_lo(20'h77777, 1, 2));
        look(32'h6600_5000, 0, CMP, 0, 0);
        chk(rsp_status == 0 && upd_idx == 7'b1_1_00101, "R1 fetch bank hit", 32'(upd_idx), 32'h65);

        // R2 single-field corruptions
        load(0, 0, 7, 32'h7700_7000, HI & 32'h7FFF_FFFF, mk_lo(20'h1, 1, 2));
        look(32'h7700_7000, 1, CMP, 0, 0);
        chk(rsp_status == 1, "R2 valid clear", 32'(rsp_status), 1);
        load(0, 0, 7, 32'h7700_7000, HI | 32'h40, mk_lo(20'h1, 1, 2));
        look(32'h7700_7000, 1, CMP | 32'h40, 0, 0);
        chk(rsp_status == 1, "R2 hash select", 32'(rsp_status), 1);
        load(0, 0, 7, 32'h7700_7000, HI, mk_lo(20'h1, 1, 2));
        look(32'h7700_7000, 1, CMP ^ 32'h0000_0100, 0, 0);
        chk(rsp_status == 1, "R2 compare word", 32'(rsp_status), 1);
        load(0, 0, 7, 32'h7701_7000, HI, mk_lo(20'h1, 1, 2));
        look(32'h7700_7000, 1, CMP, 0, 0);
        chk(rsp_status == 1, "R2 page", 32'(rsp_status), 1);
        load(0, 0, 7, 32'h7700_7000, HI, mk_lo(20'h1, 1, 2));
        look(32'h7700_7FFF, 1, CMP, 0, 0);
        chk(rsp_status == 0, "R2 full match", 32'(rsp_status), 0);

        // R3 R5 two-way patterns in data set 9
        load(0, 0, 9, 32'h8800_9000, HI, mk_lo(20'hA, 1, 2));
        load(0, 1, 9, 32'h8800_9000, HI, mk_lo(20'hA, 1, 2) | 32'h800);
        look(32'h8800_9000, 2, CMP, 0, 0);
        chk(rsp_status == 0 && upd_idx == 7'd9, "R5 lowest grant", 32'(upd_idx), 9);
        load(0, 0, 9, 32'h8800_9000, HI, mk_lo(20'hA, 1, 3));
        load(0, 1, 9, 32'h8800_9000, HI, mk_lo(20'hA, 1, 3) | 32'h800);
        look(32'h8800_9000, 2, CMP, 0, 0);
        chk(rsp_status == 2 && upd_idx == 7'd41, "R5 deny last way", 32'(upd_idx), 41);
        chk(rsp_raddr == (mk_lo(20'hA, 1, 3) | 32'h800), "R5 deny raddr", rsp_raddr, mk_lo(20'hA, 1, 3) | 32'h800);
        load(0, 1, 9, 32'h8800_9000, HI, mk_lo(20'hA, 1, 2));
        look(32'h8800_9000, 2, CMP, 0, 0);
        chk(rsp_status == 2 && upd_idx == 7'd9, "R3 pp mismatch skipped", 32'(upd_idx), 9);
        load(0, 0, 9, 32'h8800_9000, 32'h0, mk_lo(20'hA, 1, 3));
        look(32'h8800_9000, 2, CMP, 0, 0);
        chk(rsp_status == 0 && upd_idx == 7'd41, "R5 second way only", 32'(upd_idx), 41);
        load(0, 0, 9, 32'h8800_9000, HI, mk_lo(20'hB, 1, 0));
        look(32'h8800_9000, 1, CMP, 1, 0);
        chk(rsp_status == 2 && upd_idx == 7'd9, "R3 rpn mismatch skipped", 32'(upd_idx), 9);

        // R6 R7 R10 back-to-back write-back visibility
        load(0, 0, 11, 32'h9900_B000, HI, mk_lo(20'hC, 0, 2));
        @(negedge clk);
        drive(32'h9900_B000, 1, CMP, 0, 0);
        @(negedge clk);
        drive(32'h9900_B000, 1, CMP, 0, 0);
        @(negedge clk);
        req_valid = 0;
        chk(rsp_raddr == mk_lo(20'hC, 0, 2) && rsp_perm == 3'b101, "R7 clean load", 32'(rsp_perm), 5);
        chk(upd_word == (mk_lo(20'hC, 0, 2) | 32'h100), "R6 ref word", upd_word, mk_lo(20'hC, 0, 2) | 32'h100);
        @(negedge clk);
        chk(rsp_valid && rsp_raddr == (mk_lo(20'hC, 0, 2) | 32'h100), "R10 sees update",
            rsp_raddr, mk_lo(20'hC, 0, 2) | 32'h100);
        look(32'h9900_B000, 2, CMP, 0, 0);
        chk(rsp_status == 0 && upd_word[7] && rsp_perm[1], "R7 store sets changed", upd_word, mk_lo(20'hC, 1, 2) | 32'h100);
        look(32'h9900_B000, 1, CMP, 0, 0);
        chk(rsp_raddr[7] && rsp_perm == 3'b111, "R7 dirty keeps write", 32'(rsp_perm), 7);

        done = 1'b1;
        finish_run();
    end
endmodule